// File: doc/BRIEF.md
# Timer Sequencer Run Control

This block steps a program address for an instruction-driven timer engine. Each instruction takes a fixed number of clock cycles. After the last cycle of an instruction the address moves to the next slot. When the address reaches a programmable loop end, it returns to zero. The instruction set and the program memory are not part of this block. Here an instruction is only a fixed-length step.

Two kinds of control can stop the stepping:

- **Debug suspend.** When the halt mode is selected, the debug suspend input freezes the engine, but only at an instruction boundary. When the halt mode is not selected, the input is ignored.
- **Turn-off request.** This request is honoured only when the loop wraps. The engine then parks at address zero and raises an idle flag. Software can gate the clock safely once it sees the flag.

Host accesses over a small register bus stay live in every state. The bus reaches the configuration, the current address and a capture field. The capture field is loaded by a strobe input. It can be set to clear itself when the host reads it, so that a non-zero read always means a fresh event.

Top module: `tmr_seq_ctrl`

## Requirements
- R1: After reset the address is 0, the idle flag is 0, the capture field is 0, and the config register reads halt mode 0, read-clear 0, turn-off 0 and loop end all ones.
- R2: Each instruction lasts STEP_CYC cycles. `step_o` is high in the last cycle of an instruction, and the address rises by one on the edge that ends it.
- R3: When an instruction ends with the address at or above the loop end, the address goes to 0 instead.
- R4: With halt mode set (config bit 0 = 1) and `dbg_susp_i` high, an instruction already under way completes. The engine then holds at the next instruction boundary with `halted_o` high, and it continues when `dbg_susp_i` falls.
- R5: With halt mode clear, `dbg_susp_i` has no effect on stepping and `halted_o` stays 0.
- R6: While the engine is halted, register writes take effect and reads return current values.
- R7: When the turn-off bit (config bit 2) is set, stepping continues until the loop wraps. From the edge of that wrap, `idle_o` is 1 and the address holds at 0.
- R8: Clearing the turn-off bit while idle drops `idle_o` on the following edge, and stepping restarts from address 0.
- R9: A `cap_stb_i` pulse loads `cap_data_i` into the capture field, which reads at bus address 2 in bits [DATA_W-1:0].
- R10: With read-clear set (config bit 1), a read of address 2 returns the value and the field is 0 from the next edge on. With read-clear clear, a read leaves the field unchanged.
- R11: If a strobe and a clearing read fall in the same cycle, the read returns the old value and the strobed value is retained.
- R12: The register map is as follows:
  - Address 0 is the config register. Bit 0 is halt mode, bit 1 is read-clear, bit 2 is turn-off, bit 3 is idle (read-only), and bits [8 +: ADDR_W] hold the loop end.
  - Address 1 holds the current address in bits [ADDR_W-1:0] and is read-only.
  - Writes to addresses 1, 2 and 3 are ignored, and address 3 reads 0.
  - Read data is combinational from `bus_addr_i` while `bus_re_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbg_susp_i | input | 1 | Debug suspend request |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | BUS_W | Write data |
| bus_rdata_o | output | BUS_W | Read data, combinational |
| cap_stb_i | input | 1 | Capture event strobe |
| cap_data_i | input | DATA_W | Capture value |
| pc_o | output | ADDR_W | Current program address |
| step_o | output | 1 | Last cycle of an instruction |
| halted_o | output | 1 | Held at a boundary by suspend |
| idle_o | output | 1 | Parked after a turn-off |

## Verification
The hardest situations to reach are those where a control input lands at every possible phase of an instruction or a loop. A suspend raised in the middle of an instruction must still let that instruction finish. A turn-off raised anywhere in the loop must still wait for the wrap. The bench therefore raises suspend and turn-off at every cycle offset across several instructions. A cycle-level arithmetic model of address, phase and idle state predicts every cycle. Capture strobes are placed in the same cycle as clearing reads to reach the collision case.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;
  typedef enum logic [1:0] {
    REG_CFG  = 2'd0,
    REG_PC   = 2'd1,
    REG_CAP  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int CFG_HALT_BIT = 0;
  localparam int CFG_CLR_BIT  = 1;
  localparam int CFG_OFF_BIT  = 2;
  localparam int CFG_IDLE_BIT = 3;
  localparam int CFG_LE_LSB   = 8;

  typedef struct packed {
    logic halt_mode;
    logic rd_clr;
    logic off_req;
  } ctl_t;
endpackage

// File: rtl/seq_capture.sv
`timescale 1ns/1ps
module seq_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] cap_o
);
  logic [DATA_W-1:0] cap_q;

  // new event beats a clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cap_q <= '0;
    else if (stb_i)  cap_q <= data_i;
    else if (clr_i)  cap_q <= '0;
  end

  assign cap_o = cap_q;
endmodule

// File: rtl/seq_engine.sv
`timescale 1ns/1ps
module seq_engine #(
  parameter int ADDR_W   = 9,
  parameter int STEP_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_mode_i,
  input  logic              off_req_i,
  input  logic [ADDR_W-1:0] loop_end_i,
  input  logic              susp_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              step_o,
  output logic              halted_o,
  output logic              idle_o
);
  localparam int CNT_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

  logic              last;
  logic              at_start;
  logic              stall;
  logic              adv;
  logic              idle_q;
  logic [ADDR_W-1:0] pc_q;

  assign stall = halt_mode_i && susp_i && at_start;
  assign adv   = !idle_q && !stall;

  generate
    if (STEP_CYC == 1) begin : g_single
      assign last     = 1'b1;
      assign at_start = 1'b1;
    end else begin : g_multi
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  cnt_q <= '0;
        else if (adv) cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
      assign last     = (cnt_q == CNT_W'(STEP_CYC - 1));
      assign at_start = (cnt_q == '0);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      idle_q <= 1'b0;
    end else begin
      if (idle_q && !off_req_i) idle_q <= 1'b0;
      if (adv && last) begin
        if (pc_q >= loop_end_i) begin
          pc_q <= '0;
          if (off_req_i) idle_q <= 1'b1;
        end else begin
          pc_q <= pc_q + 1'b1;
        end
      end
    end
  end

  assign pc_o     = pc_q;
  assign step_o   = adv && last;
  assign halted_o = !idle_q && stall;
  assign idle_o   = idle_q;
endmodule

// File: rtl/seq_regs.sv
`timescale 1ns/1ps
module seq_regs
  import seq_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16,
  parameter int BUS_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              idle_i,
  input  logic [DATA_W-1:0] cap_i,
  output ctl_t              ctl_o,
  output logic [ADDR_W-1:0] loop_end_o,
  output logic [BUS_W-1:0]  rdata_o
);
  reg_sel_e          sel;
  ctl_t              ctl_q;
  logic [ADDR_W-1:0] le_q;
  logic              unused_wdata;

  assign sel          = reg_sel_e'(addr_i);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      le_q  <= '1;
    end else if (we_i && sel == REG_CFG) begin
      ctl_q.halt_mode <= wdata_i[CFG_HALT_BIT];
      ctl_q.rd_clr    <= wdata_i[CFG_CLR_BIT];
      ctl_q.off_req   <= wdata_i[CFG_OFF_BIT];
      le_q            <= wdata_i[CFG_LE_LSB +: ADDR_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      REG_CFG: begin
        rdata_o[CFG_HALT_BIT]             = ctl_q.halt_mode;
        rdata_o[CFG_CLR_BIT]              = ctl_q.rd_clr;
        rdata_o[CFG_OFF_BIT]              = ctl_q.off_req;
        rdata_o[CFG_IDLE_BIT]             = idle_i;
        rdata_o[CFG_LE_LSB +: ADDR_W]     = le_q;
      end
      REG_PC:   rdata_o[ADDR_W-1:0] = pc_i;
      REG_CAP:  rdata_o[DATA_W-1:0] = cap_i;
      REG_NONE: rdata_o = '0;
      default:  rdata_o = '0;
    endcase
  end

  assign ctl_o      = ctl_q;
  assign loop_end_o = le_q;
endmodule

// File: rtl/tmr_seq_ctrl.sv
`timescale 1ns/1ps
module tmr_seq_ctrl
  import seq_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int STEP_CYC = 4,
  parameter int DATA_W   = 16,
  parameter int BUS_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbg_susp_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic              cap_stb_i,
  input  logic [DATA_W-1:0] cap_data_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              step_o,
  output logic              halted_o,
  output logic              idle_o
);
  ctl_t              ctl;
  logic [ADDR_W-1:0] loop_end;
  logic [DATA_W-1:0] cap_q;
  logic              rd_clr_hit;

  assign rd_clr_hit = bus_re_i && (reg_sel_e'(bus_addr_i) == REG_CAP) && ctl.rd_clr;

  seq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .pc_i      (pc_o),
    .idle_i    (idle_o),
    .cap_i     (cap_q),
    .ctl_o     (ctl),
    .loop_end_o(loop_end),
    .rdata_o   (bus_rdata_o)
  );

  seq_engine #(.ADDR_W(ADDR_W), .STEP_CYC(STEP_CYC)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .halt_mode_i(ctl.halt_mode),
    .off_req_i  (ctl.off_req),
    .loop_end_i (loop_end),
    .susp_i     (dbg_susp_i),
    .pc_o       (pc_o),
    .step_o     (step_o),
    .halted_o   (halted_o),
    .idle_o     (idle_o)
  );

  seq_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_i (cap_stb_i),
    .data_i(cap_data_i),
    .clr_i (rd_clr_hit),
    .cap_o (cap_q)
  );
endmodule

// File: rtl/seq_ctrl_chk.sv
`timescale 1ns/1ps
module seq_ctrl_chk #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] pc_i,
  input logic              step_i,
  input logic              halted_i,
  input logic              idle_i,
  input logic              halt_mode_i,
  input logic [ADDR_W-1:0] loop_end_i,
  input logic [DATA_W-1:0] cap_i,
  input logic              cap_stb_i,
  input logic [DATA_W-1:0] cap_data_i,
  input logic              rd_clr_hit_i
);
  a_r2_pc_moves_on_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pc_i) |-> $past(step_i));

  a_r2_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && pc_i < loop_end_i) |=> pc_i == ADDR_W'($past(pc_i) + 1'b1));

  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && pc_i >= loop_end_i) |=> pc_i == '0);

  a_r4_halt_blocks_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |-> !step_i);

  a_r5_ignore_no_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_mode_i |-> !halted_i);

  a_r7_idle_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> (pc_i == '0 && !step_i));

  a_r7_idle_after_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_i) |-> $past(step_i));

  a_r10_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_hit_i && !cap_stb_i) |=> cap_i == '0);

  a_r11_capture_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_stb_i |=> cap_i == $past(cap_data_i));
endmodule

bind tmr_seq_ctrl seq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pc_i        (pc_o),
  .step_i      (step_o),
  .halted_i    (halted_o),
  .idle_i      (idle_o),
  .halt_mode_i (ctl.halt_mode),
  .loop_end_i  (loop_end),
  .cap_i       (cap_q),
  .cap_stb_i   (cap_stb_i),
  .cap_data_i  (cap_data_i),
  .rd_clr_hit_i(rd_clr_hit)
);

// File: tb/sim_tmr_seq_ctrl.sv
`timescale 1ns/1ps
module sim_tmr_seq_ctrl;
  localparam int AW = 3;
  localparam int SC = 3;
  localparam int DW = 8;
  localparam int BW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          susp = 1'b0;
  logic          we = 1'b0;
  logic          re = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [BW-1:0] wdata = '0;
  logic [BW-1:0] rdata;
  logic          stb = 1'b0;
  logic [DW-1:0] sdata = '0;
  logic [AW-1:0] pc;
  logic          step;
  logic          halted;
  logic          idle;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";

  // reference state
  int m_pc = 0, m_cnt = 0, m_idle = 0, m_cap = 0;
  int m_halt = 0, m_clr = 0, m_off = 0, m_le = 7;

  always #4 clk = ~clk;

  tmr_seq_ctrl #(.ADDR_W(AW), .STEP_CYC(SC), .DATA_W(DW), .BUS_W(BW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .dbg_susp_i(susp),
    .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .cap_stb_i(stb), .cap_data_i(sdata),
    .pc_o(pc), .step_o(step), .halted_o(halted), .idle_o(idle)
  );

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", t, act, exp);
    end
  endtask

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_halt | (m_clr << 1) | (m_off << 2) | (m_idle << 3) | (m_le << 8);
      1: return m_pc;
      2: return m_cap;
      default: return 0;
    endcase
  endfunction

  // inputs already driven at a negedge
  task automatic cyc();
    int stall, adv, last, stp;
    #1;
    stall = (m_halt && susp && m_cnt == 0) ? 1 : 0;
    adv   = (!m_idle && !stall) ? 1 : 0;
    last  = (m_cnt == SC - 1) ? 1 : 0;
    stp   = adv & last;
    chk({tag, " step"}, int'(step), stp);
    chk({tag, " halted"}, int'(halted), (!m_idle && stall) ? 1 : 0);
    if (re) chk({tag, " rdata"}, int'(rdata), exp_rd(int'(addr)));
    if (m_idle && !m_off) m_idle = 0;
    if (adv) begin
      if (last) begin
        m_cnt = 0;
        if (m_pc >= m_le) begin
          m_pc = 0;
          if (m_off) m_idle = 1;
        end else m_pc = m_pc + 1;
      end else m_cnt = m_cnt + 1;
    end
    if (stb) m_cap = int'(sdata);
    else if (re && addr == 2'd2 && m_clr) m_cap = 0;
    if (we && addr == 2'd0) begin
      m_halt = int'(wdata[0]);
      m_clr  = int'(wdata[1]);
      m_off  = int'(wdata[2]);
      m_le   = int'(wdata[8 +: AW]);
    end
    @(negedge clk);
    chk({tag, " pc"}, int'(pc), m_pc);
    chk({tag, " idle"}, int'(idle), m_idle);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(input int a, input int d);
    we = 1'b1; addr = 2'(a); wdata = BW'(d);
    cyc();
    we = 1'b0;
  endtask

  task automatic rd(input int a);
    re = 1'b1; addr = 2'(a);
    cyc();
    re = 1'b0;
  endtask

  task automatic wcfg(input int h, input int c, input int o, input int le);
    wr(0, h | (c << 1) | (o << 2) | (le << 8));
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    tag = "R1";
    chk("R1 pc", int'(pc), 0);
    chk("R1 idle", int'(idle), 0);
    rd(0); rd(2);

    // R2 R3 loop-end sweep
    for (int le = 0; le < 8; le++) begin
      tag = "R3";
      wcfg(0, 0, 0, le);
      tag = "R2";
      run(2 * SC * (le + 1) + 2);
      rd(1);
    end

    // R12 ignored writes, empty slot
    tag = "R12";
    wr(1, 5); rd(1);
    wr(2, 8'hA5); rd(2);
    wr(3, 32'hFFFF_FFFF); rd(3); rd(0);

    // R4 R6 suspend at every phase
    for (int j = 0; j < 2 * SC + 1; j++) begin
      tag = "R4";
      wcfg(1, 0, 0, 5);
      run(j);
      susp = 1'b1;
      run(SC + 2);
      tag = "R6";
      wcfg(1, 0, 0, 4); rd(0); rd(1);
      run(2);
      tag = "R4";
      susp = 1'b0;
      run(SC + 1);
    end

    // R5 ignore mode
    for (int j = 0; j < SC + 1; j++) begin
      tag = "R5";
      wcfg(0, 0, 0, 5);
      run(j);
      susp = 1'b1;
      run(2 * SC + 3);
      susp = 1'b0;
      run(1);
    end

    // R7 R8 turn-off at every phase of a loop
    for (int j = 0; j < SC * 4; j++) begin
      tag = "R7";
      wcfg(0, 0, 0, 3);
      run(j);
      wcfg(0, 0, 1, 3);
      run(SC * 4 + 3);
      chk("R7 parked idle", int'(idle), 1);
      chk("R7 parked pc", int'(pc), 0);
      rd(0); rd(1);
      tag = "R8";
      wcfg(0, 0, 0, 3);
      run(2);
      chk("R8 idle released", int'(idle), 0);
      run(SC + 1);
    end

    // R7 with suspend held while idle
    tag = "R7";
    wcfg(1, 0, 1, 2);
    susp = 1'b1;
    run(SC * 3 + 3);
    susp = 1'b0;
    run(2);
    tag = "R8";
    wcfg(0, 0, 0, 2);
    run(4);

    // R9 R10 R11 capture
    for (int v = 1; v < 256; v += 37) begin
      tag = "R9";
      wcfg(0, 0, 0, 7);
      stb = 1'b1; sdata = 8'(v);
      cyc();
      stb = 1'b0;
      rd(2); rd(2);
      chk("R10 no clear kept", int'(rdata), v);
      tag = "R10";
      wcfg(0, 1, 0, 7);
      rd(2); rd(2);
      chk("R10 cleared", int'(rdata), 0);
      tag = "R11";
      stb = 1'b1; sdata = 8'(v + 1);
      cyc();
      sdata = 8'(v + 2);
      re = 1'b1; addr = 2'd2;
      #1;
      chk("R11 old value on read", int'(rdata), (v + 1) & 8'hFF);
      cyc();
      stb = 1'b0; re = 1'b0;
      rd(2);
      rd(2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule